// File: doc/BRIEF.md
# Per-Line MOESI Coherence Controller

This block keeps the coherence state of every line of a small private first-level cache in a directory-based multi-core system. Each cycle it looks at one processor request (load, store or replacement), one DMA access and one protocol message from the network. For each request it decides whether to serve it, hold it off, or send a request for exclusive permission. It then moves the addressed line to its next state. The data array, tag lookup, interconnect and the directory side are outside the block.

Two timed write-window states sit next to the clean and dirty exclusive states. They let a store complete without any network traffic, and they hold off replacements and DMA until a per-line timer expires. A store to a shared, clean-exclusive or owned line sends an exclusive-permission request and parks the line in one of two transient states. The line stays there until the grant and all the acknowledgments it announces have arrived. Only then can the stalled store complete.

A read port returns the state of any line, so that neighbouring logic can see it. The line count must be a power of two.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After a synchronous reset, every line is invalid and both registered pulse outputs are low. State codes on `probe_state`: I=0, S=1, O=2, M=3, M_W=4, MM=5, MM_W=6, SM=7, OM=8.
- R2: A load (`cpu_op`=0) is served in every state except I. In I, `cpu_ready` stays low.
- R3: In M_W and MM_W, a replacement (`cpu_op`=2) sees `cpu_ready` low. A DMA access sees `dma_ready` low in those states. Elsewhere `dma_ready` follows `dma_valid`, and DMA never changes a line state.
- R4: A line that enters M_W or MM_W stays there for exactly WINDOW cycles. It then moves on its own to M or MM, respectively.
- R5: A store (`cpu_op`=1) to a line in M_W is accepted in the same cycle. The line moves to MM_W, the timer restarts at WINDOW, and no exclusive request is sent.
- R6: A valid store to a line in S or M is not accepted. The line moves to SM. A valid store to a line in O is not accepted, and the line moves to OM. In both cases `getx_valid` pulses for one cycle in the next cycle, with `getx_line` set to the line.
- R7: In SM and OM, stores and replacements see `cpu_ready` low and loads are served.
- R8: A grant message (`net_kind`=2) in SM or OM adds `net_acks` to a per-line count. Each acknowledgment (`net_kind`=3) subtracts one. Acknowledgments may arrive before the grant. Once a grant has been seen and the count is zero, the line moves to MM_W. A grant that leaves acknowledgments outstanding moves SM to OM.
- R9: Stores are accepted only in M_W, MM and MM_W. A store accepted in MM or MM_W leaves the state unchanged, so a store that stalled completes once the line reaches MM_W.
- R10: A shared fill (`net_kind`=0) moves an I line to S. An exclusive fill (`net_kind`=1) moves an I line to M_W.
- R11: An invalidation (`net_kind`=4) moves S to I and is ignored in other states. A forwarded read (`net_kind`=5) moves M or MM to O. In that case `supply_valid` pulses in the next cycle with `supply_line` set to the line. In other states a forwarded read does nothing.
- R12: A replacement is accepted in I, S, O, M and MM and leaves the line in I. Requests addressed to one line do not change any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 load, 1 store, 2 replacement |
| cpu_line | input | LW | Line addressed by the processor |
| cpu_ready | output | 1 | Request may complete this cycle |
| dma_valid | input | 1 | DMA access valid |
| dma_line | input | LW | Line addressed by DMA |
| dma_ready | output | 1 | DMA access accepted |
| net_valid | input | 1 | Network message valid |
| net_kind | input | 3 | Message kind (see R8, R10, R11) |
| net_line | input | LW | Line the message concerns |
| net_acks | input | ACK_W | Acknowledgment count carried by a grant |
| getx_valid | output | 1 | Exclusive-permission request pulse |
| getx_line | output | LW | Line of that request |
| supply_valid | output | 1 | Data-supply pulse for a forwarded read |
| supply_line | output | LW | Line being supplied |
| probe_line | input | LW | Line whose state is read out |
| probe_state | output | 4 | State of `probe_line` |

## Verification
The hardest situation to reach is the acknowledgment race. In it, an acknowledgment arrives while the line is still in SM and before the grant, and the grant then announces more acknowledgments than are still outstanding. The bench gets there by driving the network messages itself: it sends an acknowledgment right after the store is rejected, then a grant announcing two, then the last acknowledgment. It checks that the line goes SM, then OM, then MM_W only on the final message. The two window states exist only for WINDOW cycles, so the bench probes each one within that time, on every line. It also checks the exact cycle of expiry, including after a store restarts the timer partway through the window.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [3:0] {
    ST_I   = 4'd0,
    ST_S   = 4'd1,
    ST_O   = 4'd2,
    ST_M   = 4'd3,
    ST_MW  = 4'd4,
    ST_MM  = 4'd5,
    ST_MMW = 4'd6,
    ST_SM  = 4'd7,
    ST_OM  = 4'd8
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_REPL  = 2'd2,
    OP_NONE  = 2'd3
  } cpu_op_e;

  typedef enum logic [2:0] {
    MSG_FILL_S   = 3'd0,
    MSG_FILL_E   = 3'd1,
    MSG_GRANT    = 3'd2,
    MSG_ACK      = 3'd3,
    MSG_INV      = 3'd4,
    MSG_FWD_READ = 3'd5,
    MSG_RSVD6    = 3'd6,
    MSG_RSVD7    = 3'd7
  } net_msg_e;

  function automatic logic in_window(line_st_e s);
    return (s == ST_MW) || (s == ST_MMW);
  endfunction

  function automatic logic in_upgrade(line_st_e s);
    return (s == ST_SM) || (s == ST_OM);
  endfunction

endpackage

// File: rtl/moesi_access_gate.sv
module moesi_access_gate
  import moesi_pkg::*;
(
  input  line_st_e cpu_state,
  input  cpu_op_e  cpu_op,
  input  line_st_e dma_state,
  output logic     cpu_ok,
  output logic     dma_ok
);

  always_comb begin
    cpu_ok = 1'b0;
    case (cpu_op)
      OP_LOAD:  cpu_ok = (cpu_state != ST_I);
      OP_STORE: cpu_ok = (cpu_state == ST_MW) || (cpu_state == ST_MM) ||
                         (cpu_state == ST_MMW);
      OP_REPL:  cpu_ok = (cpu_state == ST_I) || (cpu_state == ST_S) ||
                         (cpu_state == ST_O) || (cpu_state == ST_M) ||
                         (cpu_state == ST_MM);
      default:  cpu_ok = 1'b0;
    endcase
  end

  assign dma_ok = !in_window(dma_state);

endmodule

// File: rtl/moesi_line_fsm.sv
module moesi_line_fsm
  import moesi_pkg::*;
#(
  parameter int WINDOW = 8,
  parameter int ACK_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_hit,
  input  cpu_op_e          cpu_op,
  input  logic             cpu_ok,
  input  logic             net_hit,
  input  net_msg_e         net_kind,
  input  logic [ACK_W-1:0] net_acks,
  output line_st_e         state_q
);

  localparam int TMR_W = $clog2(WINDOW + 1);
  localparam int CNT_W = ACK_W + 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WINDOW);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);
  localparam logic signed [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  line_st_e                  state_d;
  logic [TMR_W-1:0]          tmr_q, tmr_d;
  logic signed [CNT_W-1:0]   cnt_q, cnt_d, cnt_sum, cnt_dec;
  logic                      grant_q, grant_d;

  assign cnt_sum = cnt_q + $signed({1'b0, net_acks});
  assign cnt_dec = cnt_q - CNT_ONE;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    cnt_d   = cnt_q;
    grant_d = grant_q;

    // window countdown, expiry falls back to the untimed exclusive state
    if (in_window(state_q)) begin
      if (tmr_q <= TMR_ONE) begin
        state_d = (state_q == ST_MW) ? ST_M : ST_MM;
        tmr_d   = '0;
      end else begin
        tmr_d = tmr_q - TMR_ONE;
      end
    end

    if (cpu_hit) begin
      case (cpu_op)
        OP_STORE: begin
          if (state_q == ST_MW && cpu_ok) begin
            state_d = ST_MMW;
            tmr_d   = TMR_LOAD;
          end else if (state_q == ST_S || state_q == ST_M) begin
            state_d = ST_SM;
            cnt_d   = '0;
            grant_d = 1'b0;
          end else if (state_q == ST_O) begin
            state_d = ST_OM;
            cnt_d   = '0;
            grant_d = 1'b0;
          end
        end
        OP_REPL: begin
          if (cpu_ok) state_d = ST_I;
        end
        default: ;
      endcase
    end

    if (net_hit) begin
      case (net_kind)
        MSG_FILL_S: begin
          if (state_q == ST_I) state_d = ST_S;
        end
        MSG_FILL_E: begin
          if (state_q == ST_I) begin
            state_d = ST_MW;
            tmr_d   = TMR_LOAD;
          end
        end
        MSG_GRANT: begin
          if (in_upgrade(state_q)) begin
            if (cnt_sum == '0) begin
              state_d = ST_MMW;
              tmr_d   = TMR_LOAD;
              grant_d = 1'b0;
              cnt_d   = '0;
            end else begin
              state_d = ST_OM;
              grant_d = 1'b1;
              cnt_d   = cnt_sum;
            end
          end
        end
        MSG_ACK: begin
          if (in_upgrade(state_q)) begin
            if (grant_q && cnt_dec == '0) begin
              state_d = ST_MMW;
              tmr_d   = TMR_LOAD;
              grant_d = 1'b0;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_dec;
            end
          end
        end
        MSG_INV: begin
          if (state_q == ST_S) state_d = ST_I;
        end
        MSG_FWD_READ: begin
          if (state_q == ST_M || state_q == ST_MM) state_d = ST_O;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_I;
      tmr_q   <= '0;
      cnt_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      cnt_q   <= cnt_d;
      grant_q <= grant_d;
    end
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WINDOW    = 8,
  parameter int ACK_W     = 3,
  localparam int LW       = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  input  logic [LW-1:0]    cpu_line,
  output logic             cpu_ready,
  input  logic             dma_valid,
  input  logic [LW-1:0]    dma_line,
  output logic             dma_ready,
  input  logic             net_valid,
  input  logic [2:0]       net_kind,
  input  logic [LW-1:0]    net_line,
  input  logic [ACK_W-1:0] net_acks,
  output logic             getx_valid,
  output logic [LW-1:0]    getx_line,
  output logic             supply_valid,
  output logic [LW-1:0]    supply_line,
  input  logic [LW-1:0]    probe_line,
  output logic [3:0]       probe_state
);

  cpu_op_e  op_c;
  net_msg_e kind_c;
  line_st_e line_state [NUM_LINES];
  line_st_e cpu_state, dma_state, net_state;
  logic     cpu_ok, dma_ok;
  logic     getx_d, supply_d;

  assign op_c   = cpu_op_e'(cpu_op);
  assign kind_c = net_msg_e'(net_kind);

  assign cpu_state   = line_state[cpu_line];
  assign dma_state   = line_state[dma_line];
  assign net_state   = line_state[net_line];
  assign probe_state = line_state[probe_line];

  moesi_access_gate u_gate (
    .cpu_state (cpu_state),
    .cpu_op    (op_c),
    .dma_state (dma_state),
    .cpu_ok    (cpu_ok),
    .dma_ok    (dma_ok)
  );

  assign cpu_ready = cpu_ok;
  assign dma_ready = dma_valid && dma_ok;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      moesi_line_fsm #(
        .WINDOW (WINDOW),
        .ACK_W  (ACK_W)
      ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cpu_hit  (cpu_valid && (cpu_line == LW'(g))),
        .cpu_op   (op_c),
        .cpu_ok   (cpu_ok),
        .net_hit  (net_valid && (net_line == LW'(g))),
        .net_kind (kind_c),
        .net_acks (net_acks),
        .state_q  (line_state[g])
      );
    end
  endgenerate

  assign getx_d = cpu_valid && (op_c == OP_STORE) &&
                  ((cpu_state == ST_S) || (cpu_state == ST_M) || (cpu_state == ST_O));
  assign supply_d = net_valid && (kind_c == MSG_FWD_READ) &&
                    ((net_state == ST_M) || (net_state == ST_MM));

  always_ff @(posedge clk) begin
    if (rst) begin
      getx_valid   <= 1'b0;
      getx_line    <= '0;
      supply_valid <= 1'b0;
      supply_line  <= '0;
    end else begin
      getx_valid   <= getx_d;
      getx_line    <= cpu_line;
      supply_valid <= supply_d;
      supply_line  <= net_line;
    end
  end

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk
  import moesi_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     cpu_valid,
  input logic [1:0] cpu_op,
  input logic     cpu_ready,
  input line_st_e cpu_state,
  input logic     dma_valid,
  input logic     dma_ready,
  input line_st_e dma_state,
  input logic     net_valid,
  input logic [2:0] net_kind,
  input logic     getx_valid,
  input logic     supply_valid
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!getx_valid && !supply_valid));

  a_r3_window_blocks_repl: assert property (@(posedge clk) disable iff (rst)
    (cpu_op == 2'd2 && in_window(cpu_state)) |-> !cpu_ready);

  a_r3_window_blocks_dma: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && in_window(dma_state)) |-> !dma_ready);

  a_r5_window_store_silent: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_op == 2'd1 && cpu_state == ST_MW) |=> !getx_valid);

  a_r6_getx_from_stall: assert property (@(posedge clk) disable iff (rst)
    getx_valid |-> $past(cpu_valid && cpu_op == 2'd1 && !cpu_ready));

  a_r9_store_needs_exclusive: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && cpu_op == 2'd1) |->
      (cpu_state == ST_MW || cpu_state == ST_MM || cpu_state == ST_MMW));

  a_r11_supply_from_fwd: assert property (@(posedge clk) disable iff (rst)
    supply_valid |-> $past(net_valid && net_kind == 3'd5));

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_valid    (cpu_valid),
  .cpu_op       (cpu_op),
  .cpu_ready    (cpu_ready),
  .cpu_state    (cpu_state),
  .dma_valid    (dma_valid),
  .dma_ready    (dma_ready),
  .dma_state    (dma_state),
  .net_valid    (net_valid),
  .net_kind     (net_kind),
  .getx_valid   (getx_valid),
  .supply_valid (supply_valid)
);

// File: tb/test_moesi_line_ctrl.sv
module test_moesi_line_ctrl;
  import moesi_pkg::*;

  localparam int CLK_PERIOD = 20;
  localparam int NL  = 4;
  localparam int WIN = 8;
  localparam int AW  = 3;
  localparam int LW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0, cpu_ready;
  logic [1:0] cpu_op = '0;
  logic [LW-1:0] cpu_line = '0;
  logic dma_valid = 1'b0, dma_ready;
  logic [LW-1:0] dma_line = '0;
  logic net_valid = 1'b0;
  logic [2:0] net_kind = '0;
  logic [LW-1:0] net_line = '0;
  logic [AW-1:0] net_acks = '0;
  logic getx_valid, supply_valid;
  logic [LW-1:0] getx_line, supply_line;
  logic [LW-1:0] probe_line = '0;
  logic [3:0] probe_state;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_line_ctrl #(.NUM_LINES(NL), .WINDOW(WIN), .ACK_W(AW)) i_moesi_line_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line), .cpu_ready(cpu_ready),
    .dma_valid(dma_valid), .dma_line(dma_line), .dma_ready(dma_ready),
    .net_valid(net_valid), .net_kind(net_kind), .net_line(net_line), .net_acks(net_acks),
    .getx_valid(getx_valid), .getx_line(getx_line),
    .supply_valid(supply_valid), .supply_line(supply_line),
    .probe_line(probe_line), .probe_state(probe_state)
  );

  task automatic expect_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int ln, input int exp);
    probe_line = LW'(ln);
    #1;
    expect_eq(req, int'(probe_state), exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
  endtask

  task automatic net_send(input int kind, input int ln, input int acks);
    @(negedge clk);
    net_valid = 1'b1;
    net_kind  = 3'(kind);
    net_line  = LW'(ln);
    net_acks  = AW'(acks);
    @(negedge clk);
    net_valid = 1'b0;
  endtask

  task automatic cpu_try(input int op, input int ln, output bit rdy);
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_op    = 2'(op);
    cpu_line  = LW'(ln);
    #1 rdy = cpu_ready;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic peek_ready(input int op, input int ln, output bit rdy);
    cpu_valid = 1'b0;
    cpu_op    = 2'(op);
    cpu_line  = LW'(ln);
    #1 rdy = cpu_ready;
  endtask

  task automatic peek_dma(input int ln, output bit rdy);
    dma_valid = 1'b1;
    dma_line  = LW'(ln);
    #1 rdy = dma_ready;
    dma_valid = 1'b0;
  endtask

  function automatic bit exp_cpu(input int s, input int op);
    case (op)
      0: return s != 0;
      1: return s == 4 || s == 5 || s == 6;
      2: return s == 0 || s == 1 || s == 2 || s == 3 || s == 5;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_dma(input int s);
    return !(s == 4 || s == 6);
  endfunction

  task automatic build(input int ln, input int s);
    bit r;
    case (s)
      1: net_send(0, ln, 0);
      2: begin net_send(1, ln, 0); wait_cyc(WIN); net_send(5, ln, 0); end
      3: begin net_send(1, ln, 0); wait_cyc(WIN); end
      4: net_send(1, ln, 0);
      5: begin net_send(1, ln, 0); cpu_try(1, ln, r); wait_cyc(WIN); end
      6: begin net_send(1, ln, 0); cpu_try(1, ln, r); end
      7: begin net_send(0, ln, 0); cpu_try(1, ln, r); end
      8: begin net_send(1, ln, 0); wait_cyc(WIN); net_send(5, ln, 0); cpu_try(1, ln, r); end
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit r;
    do_reset;

    // R1: reset state
    for (int ln = 0; ln < NL; ln++) chk_state("R1 reset state", ln, 0);
    expect_eq("R1 getx after reset", int'(getx_valid), 0);
    expect_eq("R1 supply after reset", int'(supply_valid), 0);

    // sweep: every state on every line, all request kinds (R2 R3 R7 R9 R12)
    for (int ln = 0; ln < NL; ln++) begin
      for (int s = 0; s < 9; s++) begin
        do_reset;
        build(ln, s);
        chk_state("R10 build state", ln, s);
        chk_state("R12 other line untouched", (ln + 1) % NL, 0);
        peek_ready(0, ln, r); expect_eq("R2 load ready", int'(r), int'(exp_cpu(s, 0)));
        peek_ready(1, ln, r); expect_eq("R9 store ready", int'(r), int'(exp_cpu(s, 1)));
        peek_ready(2, ln, r); expect_eq("R12 repl ready", int'(r), int'(exp_cpu(s, 2)));
        peek_dma(ln, r);      expect_eq("R3 dma ready", int'(r), int'(exp_dma(s)));
      end
    end

    // R4: window length on each line
    for (int ln = 0; ln < NL; ln++) begin
      do_reset;
      net_send(1, ln, 0);
      chk_state("R4 window entered", ln, 4);
      wait_cyc(WIN - 1);
      chk_state("R4 window last cycle", ln, 4);
      wait_cyc(1);
      chk_state("R4 window expired to M", ln, 3);
    end

    // R5: store in M_W silent, timer reload
    do_reset;
    net_send(1, 2, 0);
    wait_cyc(3);
    cpu_try(1, 2, r);
    expect_eq("R5 store accepted in M_W", int'(r), 1);
    expect_eq("R5 no getx", int'(getx_valid), 0);
    chk_state("R5 to MM_W", 2, 6);
    wait_cyc(WIN - 1);
    chk_state("R5 reload keeps MM_W", 2, 6);
    wait_cyc(1);
    chk_state("R4 MM_W expired to MM", 2, 5);

    // R6 R7 R8 R9: shared upgrade with early ack
    do_reset;
    net_send(0, 1, 0);
    cpu_try(1, 1, r);
    expect_eq("R6 store stalls in S", int'(r), 0);
    expect_eq("R6 getx pulse", int'(getx_valid), 1);
    expect_eq("R6 getx line", int'(getx_line), 1);
    chk_state("R6 S to SM", 1, 7);
    wait_cyc(1);
    expect_eq("R6 getx single pulse", int'(getx_valid), 0);
    peek_ready(0, 1, r); expect_eq("R7 load in SM", int'(r), 1);
    peek_ready(1, 1, r); expect_eq("R7 store stalls SM", int'(r), 0);
    net_send(3, 1, 0);
    chk_state("R8 early ack stays SM", 1, 7);
    net_send(2, 1, 2);
    chk_state("R8 grant leaves ack pending OM", 1, 8);
    peek_ready(1, 1, r); expect_eq("R7 store stalls OM", int'(r), 0);
    peek_ready(2, 1, r); expect_eq("R7 repl stalls OM", int'(r), 0);
    net_send(3, 1, 0);
    chk_state("R8 last ack to MM_W", 1, 6);
    cpu_try(1, 1, r);
    expect_eq("R9 stalled store completes", int'(r), 1);
    chk_state("R9 store keeps MM_W", 1, 6);

    // R6 R8: M upgrade, grant with zero acks
    do_reset;
    net_send(1, 3, 0);
    wait_cyc(WIN);
    cpu_try(1, 3, r);
    expect_eq("R6 store stalls in M", int'(r), 0);
    expect_eq("R6 getx line M", int'(getx_line), 3);
    chk_state("R6 M to SM", 3, 7);
    net_send(2, 3, 0);
    chk_state("R8 zero-ack grant to MM_W", 3, 6);

    // R6 R8 R11: owned upgrade
    do_reset;
    net_send(1, 0, 0);
    wait_cyc(WIN);
    net_send(5, 0, 0);
    expect_eq("R11 supply pulse", int'(supply_valid), 1);
    expect_eq("R11 supply line", int'(supply_line), 0);
    chk_state("R11 M to O", 0, 2);
    wait_cyc(1);
    expect_eq("R11 supply single pulse", int'(supply_valid), 0);
    cpu_try(1, 0, r);
    expect_eq("R6 getx from O", int'(getx_valid), 1);
    chk_state("R6 O to OM", 0, 8);
    net_send(2, 0, 1);
    chk_state("R8 OM waits ack", 0, 8);
    net_send(3, 0, 0);
    chk_state("R8 OM to MM_W", 0, 6);

    // R11: invalidation and ignored messages
    do_reset;
    net_send(0, 2, 0);
    net_send(5, 2, 0);
    expect_eq("R11 fwd in S no supply", int'(supply_valid), 0);
    chk_state("R11 fwd in S ignored", 2, 1);
    net_send(4, 2, 0);
    chk_state("R11 inv S to I", 2, 0);
    net_send(1, 2, 0);
    wait_cyc(WIN);
    net_send(4, 2, 0);
    chk_state("R11 inv in M ignored", 2, 3);

    // R12 R3: replacement and DMA
    do_reset;
    net_send(1, 1, 0);
    cpu_try(1, 1, r);
    cpu_try(2, 1, r);
    expect_eq("R3 repl stalls MM_W", int'(r), 0);
    chk_state("R3 MM_W kept", 1, 6);
    wait_cyc(WIN);
    cpu_try(2, 1, r);
    expect_eq("R12 repl accepted MM", int'(r), 1);
    chk_state("R12 MM to I", 1, 0);
    net_send(1, 1, 0);
    wait_cyc(WIN);
    @(negedge clk);
    dma_valid = 1'b1;
    dma_line  = 2'd1;
    #1 expect_eq("R3 dma accepted in M", int'(dma_ready), 1);
    @(negedge clk);
    dma_valid = 1'b0;
    chk_state("R3 dma leaves state", 1, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule